// File: doc/BRIEF.md
# Reduced-Register Illegal-Instruction Trap Detector

This block sits beside the decoder of a small serial RISC-V core that can be built with only sixteen general-purpose registers. Every fetched instruction arrives here as a 32-bit word. A compressed instruction arrives already expanded to that form. When reduced-register mode is enabled, the block looks for any register field that names x16..x31. Such a register must not be quietly folded onto x0..x15, so the instruction is flagged as illegal.

The block combines that result with the illegal-encoding flag from the compressed-instruction expander. When it finds a fault, it raises a one-cycle trap request into the normal trap-entry path. It also captures the faulting word and presents two serial streams, W bits per cycle and least significant bit first. One stream carries the cause code 2 and is meant for the cause register. The other carries the faulting word and is meant for the trap-value register. An interrupt that is pending in the same cycle wins: no illegal trap is raised and nothing is captured.

The range check is cheap. Only the top bit of each register field is inspected, and only for fields that the instruction's format actually uses.

Top module: `rr_trap_detect`

## Requirements
- R1: With redMode=1, a valid instruction whose format writes a register (opcodes LUI 0110111, AUIPC 0010111, JAL 1101111, JALR 1100111, LOAD 0000011, OP-IMM 0010011, OP 0110011, SYSTEM 1110011 with funct3 bits [14:12] nonzero) raises trapReq when instr[11] (top bit of rd) is 1.
- R2: With redMode=1, instr[19] (top bit of rs1) raises trapReq for JALR, LOAD, OP-IMM, STORE 0100011, BRANCH 1100011, OP, and for SYSTEM with funct3 in 001..011. instr[24] (top bit of rs2) raises trapReq for STORE, BRANCH and OP.
- R3: Bits in fields that a format does not use raise no trap. This covers instr[19] and instr[24] for LUI, AUIPC and JAL; instr[24] for I-type; instr[11] for STORE and BRANCH; instr[19] for the SYSTEM immediate forms (funct3 101..111); and everything in ECALL (32'h00000073).
- R4: With redMode=0, register fields are never checked.
- R5: cmpIllegal raises trapReq only when isCompressed=1, in either mode.
- R6: If irqPending=1 in the same cycle as an illegal instruction, trapReq stays 0 and the captured word is not replaced.
- R7: trapReq is 1 for exactly the cycle after each clock edge at which instrValid=1 with an illegal instruction. It is 0 after any edge at which instrValid=0.
- R8: After a trap, mcauseData carries the 32-bit value 2, LSB first, advancing W bits at each edge with shiftEn=1.
- R9: After a trap, mtvalData carries the faulting word, LSB first, W bits per shiftEn edge. The word rotates, so after 32/W shifts it starts again. With shiftEn=0 the stream holds.
- R10: After reset, trapReq, mtvalData and mcauseData are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redMode | input | 1 | Reduced-register (x0..x15) mode enable |
| instr | input | 32 | Fetched or expanded instruction word |
| instrValid | input | 1 | instr is valid this cycle |
| cmpIllegal | input | 1 | Expander reports an illegal compressed encoding |
| isCompressed | input | 1 | Current instruction came from a 16-bit encoding |
| irqPending | input | 1 | Interrupt pending; takes precedence |
| shiftEn | input | 1 | Advance the serial streams by W bits |
| trapReq | output | 1 | Illegal-instruction trap request |
| mcauseData | output | W | Serial cause stream |
| mtvalData | output | W | Serial faulting-word stream |

## Verification
The bench places stray set bits in fields that a format ignores: the immediate of LUI, I-type bit 24, the store immediate at bit 11, and the CSR immediate form. A decoder that tests every field regardless of format would trap on these legal words. It also drives a legal 32-bit word with cmpIllegal high, which catches an ungated expander flag, and repeats an out-of-range rd with the mode off, which catches a check that is never disabled. It walks the serial stream through more than one full rotation and then holds it. After that it applies an illegal word together with a pending interrupt and reads the held bit, so a design that lets the losing trap overwrite the capture register shows a changed bit.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  localparam int unsigned ILEN = 32;
  localparam logic [ILEN-1:0] CAUSE_ILLEGAL = 32'd2;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  typedef struct packed {
    logic load;
    logic shift;
  } strobe_t;
endpackage

// File: rtl/rrt_ctrl.sv
module rrt_ctrl
  import rrt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redMode,
  input  logic [ILEN-1:0] instr,
  input  logic            instrValid,
  input  logic            cmpIllegal,
  input  logic            isCompressed,
  input  logic            irqPending,
  input  logic            shiftEn,
  output strobe_t         strb,
  output logic            trapReq
);
  logic [6:0] opcode;
  logic [2:0] funct3;
  logic       usesRd, usesRs1, usesRs2;
  logic       regFault, cmpFault, illegal;
  logic       unusedOk;

  assign opcode   = instr[6:0];
  assign funct3   = instr[14:12];
  assign unusedOk = ^{instr[31:25], instr[23:20], instr[18:15], instr[10:7]};

  // Which register fields each format really carries
  always_comb begin
    usesRd  = 1'b0;
    usesRs1 = 1'b0;
    usesRs2 = 1'b0;
    case (opcode)
      OPC_LUI, OPC_AUIPC, OPC_JAL: usesRd = 1'b1;
      OPC_JALR, OPC_LOAD, OPC_OPIMM: begin
        usesRd  = 1'b1;
        usesRs1 = 1'b1;
      end
      OPC_STORE, OPC_BRANCH: begin
        usesRs1 = 1'b1;
        usesRs2 = 1'b1;
      end
      OPC_OP: begin
        usesRd  = 1'b1;
        usesRs1 = 1'b1;
        usesRs2 = 1'b1;
      end
      OPC_SYSTEM: begin
        usesRd  = (funct3 != 3'b000);
        usesRs1 = (funct3 != 3'b000) && !funct3[2];
      end
      default: ;
    endcase
  end

  assign regFault = redMode & ((usesRd  & instr[11]) |
                               (usesRs1 & instr[19]) |
                               (usesRs2 & instr[24]));
  assign cmpFault = cmpIllegal & isCompressed;
  assign illegal  = instrValid & (regFault | cmpFault);

  assign strb.load  = illegal & ~irqPending;
  assign strb.shift = shiftEn;

  always_ff @(posedge clk) begin
    if (!rst_n) trapReq <= 1'b0;
    else        trapReq <= strb.load;
  end

  // R6
  irq_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instrValid && irqPending |=> !trapReq);
  // R7
  no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instrValid |=> !trapReq);
  // R4
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instrValid && !redMode && !(cmpIllegal && isCompressed) |=> !trapReq);
  // R5
  cmp_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instrValid && cmpIllegal && isCompressed && !irqPending |=> trapReq);
endmodule

// File: rtl/rrt_dpath.sv
module rrt_dpath
  import rrt_pkg::*;
#(
  parameter int unsigned W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  strobe_t         strb,
  input  logic [ILEN-1:0] instr,
  output logic [W-1:0]    mtvalData,
  output logic [W-1:0]    mcauseData
);
  localparam int unsigned STEPS = ILEN / W;

  logic [ILEN-1:0] mtvalSr, causeSr;
  logic [ILEN-1:0] mtvalRot, causeRot;

  generate
    if (W < ILEN) begin : g_rot
      assign mtvalRot = {mtvalSr[W-1:0], mtvalSr[ILEN-1:W]};
      assign causeRot = {causeSr[W-1:0], causeSr[ILEN-1:W]};
    end else begin : g_full
      assign mtvalRot = mtvalSr;
      assign causeRot = causeSr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mtvalSr <= '0;
      causeSr <= '0;
    end else if (strb.load) begin
      mtvalSr <= instr;
      causeSr <= CAUSE_ILLEGAL;
    end else if (strb.shift) begin
      mtvalSr <= mtvalRot;
      causeSr <= causeRot;
    end
  end

  assign mtvalData  = mtvalSr[W-1:0];
  assign mcauseData = causeSr[W-1:0];

  initial begin
    steps_chk: assert (STEPS * W == ILEN);
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.load && !strb.shift |=> $stable(mtvalSr) && $stable(causeSr));
  // R8
  cause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> $countones(causeSr) == 1);
endmodule

// File: rtl/rr_trap_detect.sv
module rr_trap_detect
  import rrt_pkg::*;
#(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         redMode,
  input  logic [31:0]  instr,
  input  logic         instrValid,
  input  logic         cmpIllegal,
  input  logic         isCompressed,
  input  logic         irqPending,
  input  logic         shiftEn,
  output logic         trapReq,
  output logic [W-1:0] mcauseData,
  output logic [W-1:0] mtvalData
);
  strobe_t strb;

  rrt_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .redMode(redMode), .instr(instr),
    .instrValid(instrValid), .cmpIllegal(cmpIllegal),
    .isCompressed(isCompressed), .irqPending(irqPending),
    .shiftEn(shiftEn), .strb(strb), .trapReq(trapReq)
  );

  rrt_dpath #(.W(W)) i_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .instr(instr),
    .mtvalData(mtvalData), .mcauseData(mcauseData)
  );
endmodule

// File: tb/test_rr_trap_detect.sv
module test_rr_trap_detect;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redMode = 1'b1;
  logic [31:0] instr = '0;
  logic        instrValid = 1'b0;
  logic        cmpIllegal = 1'b0;
  logic        isCompressed = 1'b0;
  logic        irqPending = 1'b0;
  logic        shiftEn = 1'b0;
  logic        trapReq;
  logic [0:0]  mcauseData, mtvalData;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  typedef struct {
    logic  expTrap;
    string tag;
  } item_t;
  item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_trap_detect i_rr_trap_detect (
    .clk(clk), .rst_n(rst_n), .redMode(redMode), .instr(instr),
    .instrValid(instrValid), .cmpIllegal(cmpIllegal),
    .isCompressed(isCompressed), .irqPending(irqPending),
    .shiftEn(shiftEn), .trapReq(trapReq),
    .mcauseData(mcauseData), .mtvalData(mtvalData)
  );

  function automatic logic [31:0] mk(input logic [6:0] opc, input logic [4:0] rd,
                                     input logic [2:0] f3, input logic [4:0] rs1,
                                     input logic [4:0] rs2);
    return {7'b0, rs2, rs1, f3, rd, opc};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares trapReq just after each edge against the queue
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check(it.tag, {31'b0, trapReq}, {31'b0, it.expTrap});
      end
    end
  end

  // Driver: present one instruction for one edge, push expectation
  task automatic drive(input logic [31:0] w, input logic mode, input logic vld,
                       input logic cmp, input logic isc, input logic irq,
                       input logic exp, input string tag);
    @(negedge clk);
    instr = w; redMode = mode; instrValid = vld;
    cmpIllegal = cmp; isCompressed = isc; irqPending = irq;
    @(posedge clk);
    sbq.push_back('{exp, tag});
    @(negedge clk);
    instrValid = 1'b0; cmpIllegal = 1'b0; isCompressed = 1'b0; irqPending = 1'b0;
  endtask

  localparam logic [31:0] SERIAL_WORD = 32'hA5C30BB3;

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    check("R10 trapReq", {31'b0, trapReq}, 0);
    check("R10 mtvalData", {31'b0, mtvalData}, 0);
    check("R10 mcauseData", {31'b0, mcauseData}, 0);

    drive(mk(7'b0110011, 5'd1, 3'd0, 5'd2, 5'd3), 1, 1, 0, 0, 0, 0, "R1 legal add");
    drive(mk(7'b0110011, 5'd17, 3'd0, 5'd2, 5'd3), 1, 1, 0, 0, 0, 1, "R1 add rd=x17");
    drive(mk(7'b0110111, 5'd16, 3'd0, 5'd0, 5'd0), 1, 1, 0, 0, 0, 1, "R1 lui rd=x16");
    drive(mk(7'b0110011, 5'd1, 3'd0, 5'd16, 5'd3), 1, 1, 0, 0, 0, 1, "R2 add rs1=x16");
    drive(mk(7'b0110011, 5'd1, 3'd0, 5'd2, 5'd20), 1, 1, 0, 0, 0, 1, "R2 add rs2=x20");
    drive(mk(7'b0100011, 5'd0, 3'd2, 5'd2, 5'd31), 1, 1, 0, 0, 0, 1, "R2 sw rs2=x31");
    drive(mk(7'b1100011, 5'd0, 3'd0, 5'd18, 5'd1), 1, 1, 0, 0, 0, 1, "R2 beq rs1=x18");
    drive(mk(7'b1110011, 5'd1, 3'd1, 5'd17, 5'd0), 1, 1, 0, 0, 0, 1, "R2 csrrw rs1=x17");
    drive(mk(7'b0110111, 5'd5, 3'd7, 5'd31, 5'd31), 1, 1, 0, 0, 0, 0, "R3 lui imm bits");
    drive(mk(7'b0010011, 5'd3, 3'd0, 5'd4, 5'd16), 1, 1, 0, 0, 0, 0, "R3 addi imm bit24");
    drive(mk(7'b0100011, 5'd16, 3'd2, 5'd2, 5'd3), 1, 1, 0, 0, 0, 0, "R3 sw imm bit11");
    drive(mk(7'b1110011, 5'd1, 3'd5, 5'd17, 5'd0), 1, 1, 0, 0, 0, 0, "R3 csrrwi uimm");
    drive(32'h00000073, 1, 1, 0, 0, 0, 0, "R3 ecall");
    drive(mk(7'b0110011, 5'd17, 3'd0, 5'd16, 5'd20), 0, 1, 0, 0, 0, 0, "R4 mode off");
    drive(mk(7'b0110011, 5'd1, 3'd0, 5'd2, 5'd3), 0, 1, 1, 1, 0, 1, "R5 cmp illegal");
    drive(mk(7'b0110011, 5'd1, 3'd0, 5'd2, 5'd3), 1, 1, 1, 0, 0, 0, "R5 cmp flag ungated");
    drive(mk(7'b0110011, 5'd17, 3'd0, 5'd2, 5'd3), 1, 0, 0, 0, 0, 0, "R7 not valid");
    drive(SERIAL_WORD, 1, 1, 0, 0, 0, 1, "R7 serial word trap");

    // Serial streams: 35 steps, one past a full rotation plus three
    shiftEn = 1'b1;
    for (int k = 0; k < 35; k++) begin
      check($sformatf("R9 mtval bit %0d", k), {31'b0, mtvalData}, {31'b0, SERIAL_WORD[k % 32]});
      check($sformatf("R8 mcause bit %0d", k), {31'b0, mcauseData}, (k % 32) == 1 ? 1 : 0);
      if (k == 34) shiftEn = 1'b0;
      else @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check("R9 hold mtval", {31'b0, mtvalData}, {31'b0, SERIAL_WORD[2]});

    // Interrupt wins: no trap, no capture (new word bit0 would be 1)
    drive(mk(7'b0110011, 5'd17, 3'd0, 5'd2, 5'd3), 1, 1, 0, 0, 1, 0, "R6 irq wins");
    check("R6 mtval not captured", {31'b0, mtvalData}, {31'b0, SERIAL_WORD[2]});
    check("R6 mcause not captured", {31'b0, mcauseData}, 0);

    @(negedge clk);
    check("R7 scoreboard drained", sbq.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule